// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of peripheral interrupt request lines and turns each rising edge into a latched pending request. A fixed priority encoder picks one pending request, with the lowest line index winning, and the controller raises a single interrupt request to the processor. Alongside it, the controller drives the index of the selected line. The processor uses this index to look up the address of the matching service routine.

When the processor acknowledges, the selected request moves from pending to in service, and its pending bit clears in the same step. Other requests then become visible without waiting for software. The controller records every level that is in service. While a routine runs, only requests of strictly higher priority can reach the processor, so a higher-priority device may nest over a running routine. Requests of equal or lower priority wait. An end-of-service strobe retires the most urgent active level. The controller then resumes gating at the level that was interrupted, and service returns to that routine rather than to the main program.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all pending and in-service state, so that cpu_irq is 0, vec_idx is 0 and in_service is all zeros on the cycle after reset is sampled.
- R2: A 0-to-1 transition of a request line, sampled at a clock edge, makes that line pending from that edge onward. A line held high raises no further request. A new rising edge on a line that is already pending merges into the existing request, and only one grant results.
- R3: cpu_irq is 1 exactly when some pending line is eligible. vec_idx gives the lowest-numbered eligible pending line, index 0 being the highest priority, and is 0 when nothing is eligible.
- R4: A line is eligible only if its index is strictly smaller than the lowest index set in in_service. When in_service is empty, every line is eligible. Equal and lower priorities are therefore held back.
- R5: cpu_ack sampled high while cpu_irq is 1 sets in_service bit vec_idx and clears that line's pending bit at the same edge.
- R6: cpu_ack sampled while cpu_irq is 0 has no effect.
- R7: svc_done clears only the lowest-numbered set bit of in_service, which is the most urgent active level. When in_service is empty, svc_done has no effect.
- R8: When cpu_ack is taken in the same cycle as svc_done, the acknowledge is applied and svc_done is ignored.
- R9: If a line makes a new rising edge in the very cycle its request is acknowledged, that line stays pending for a later grant.
- R10: The in_service output shows the in-service register, with bit i set while line i is being serviced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_lines | input | NUM_LINES | Peripheral request lines, rising-edge sensitive |
| cpu_ack | input | 1 | Processor acknowledge strobe |
| svc_done | input | 1 | End-of-service strobe |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_idx | output | IDX_W | Index of the selected line |
| in_service | output | NUM_LINES | Levels currently in service |

## Verification
On every cycle, the assertions check the following:
- The handshake rules: a taken acknowledge adds exactly the advertised level, an ignored acknowledge leaves service state untouched, and a retire strobe removes exactly one level.
- The nesting rule: whenever the request is up, no in-service bit sits at or above the priority of the advertised index.
- The reset outcome.

Only the bench's scenarios can show the rest:
- the ordering of grants across a nesting and unwinding sequence;
- edge versus level sensitivity;
- the merging of repeated edges;
- the collisions of acknowledge with a retire strobe or with a fresh edge.

// File: rtl/nic_pkg.sv
package nic_pkg;

  typedef enum logic [1:0] {
    SVC_HOLD   = 2'd0,
    SVC_ENTER  = 2'd1,
    SVC_RETIRE = 2'd2
  } svc_op_e;

  // width of an index into n lines, never below one bit
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/nic_req_latch.sv
module nic_req_latch #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_lines,
  input  logic [NUM_LINES-1:0] clr_mask,
  output logic [NUM_LINES-1:0] pending
);

  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] rise;

  // rising edge per line; a fresh edge wins over a same-cycle clear
  assign rise = req_lines & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      pending <= '0;
    end else begin
      prev_q  <= req_lines;
      pending <= (pending & ~clr_mask) | rise;
    end
  end

endmodule

// File: rtl/nic_prio_arb.sv
module nic_prio_arb #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [NUM_LINES-1:0] pending,
  input  logic [NUM_LINES-1:0] in_service,
  output logic                 any_eligible,
  output logic [IDX_W-1:0]     sel_idx
);

  // mask of indices strictly below the lowest set in-service bit
  function automatic logic [NUM_LINES-1:0] nest_mask(input logic [NUM_LINES-1:0] isr);
    logic [NUM_LINES-1:0] m;
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (isr[i]) seen = 1'b1;
      m[i] = ~seen;
    end
    return m;
  endfunction

  // lowest set index, zero when empty
  function automatic logic [IDX_W-1:0] first_one(input logic [NUM_LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [NUM_LINES-1:0] allow_mask;
  logic [NUM_LINES-1:0] candidates;

  assign allow_mask   = nest_mask(in_service);
  assign candidates   = pending & allow_mask;
  assign any_eligible = |candidates;
  assign sel_idx      = first_one(candidates);

endmodule

// File: rtl/nic_service_reg.sv
module nic_service_reg #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] grant_mask,
  input  logic                 svc_done,
  output logic [NUM_LINES-1:0] in_service,
  output logic [NUM_LINES-1:0] retire_mask
);
  import nic_pkg::*;

  svc_op_e op;

  // isolate the lowest set bit: the most urgent active level
  assign retire_mask = in_service & (~in_service + NUM_LINES'(1));

  always_comb begin
    if (|grant_mask)   op = SVC_ENTER;
    else if (svc_done) op = SVC_RETIRE;
    else               op = SVC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_service <= '0;
    end else begin
      unique case (op)
        SVC_ENTER:  in_service <= in_service | grant_mask;
        SVC_RETIRE: in_service <= in_service & ~retire_mask;
        default:    in_service <= in_service;
      endcase
    end
  end

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDX_W = nic_pkg::idx_bits(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_lines,
  input  logic                 cpu_ack,
  input  logic                 svc_done,
  output logic                 cpu_irq,
  output logic [IDX_W-1:0]     vec_idx,
  output logic [NUM_LINES-1:0] in_service
);

  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] grant_mask;
  logic [NUM_LINES-1:0] retire_mask;
  logic                 ack_take;

  assign ack_take   = cpu_ack & cpu_irq;
  assign grant_mask = ack_take ? (NUM_LINES'(1) << vec_idx) : '0;

  nic_req_latch #(.NUM_LINES(NUM_LINES)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .req_lines (req_lines),
    .clr_mask  (grant_mask),
    .pending   (pending)
  );

  nic_prio_arb #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_arb (
    .pending      (pending),
    .in_service   (in_service),
    .any_eligible (cpu_irq),
    .sel_idx      (vec_idx)
  );

  nic_service_reg #(.NUM_LINES(NUM_LINES)) u_svc (
    .clk         (clk),
    .rst         (rst),
    .grant_mask  (grant_mask),
    .svc_done    (svc_done),
    .in_service  (in_service),
    .retire_mask (retire_mask)
  );

endmodule

// File: rtl/nested_irq_ctrl_chk.sv
module nested_irq_ctrl_chk #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cpu_ack,
  input logic                 svc_done,
  input logic                 cpu_irq,
  input logic [IDX_W-1:0]     vec_idx,
  input logic [NUM_LINES-1:0] in_service,
  input logic [NUM_LINES-1:0] grant_mask,
  input logic [NUM_LINES-1:0] retire_mask
);

  logic [NUM_LINES-1:0] at_or_above;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) at_or_above[i] = (i <= int'(vec_idx));
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!cpu_irq && in_service == '0));

  // R4
  nest_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> ((in_service & at_or_above) == '0));

  // R5
  ack_enters_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && cpu_irq) |=> in_service[$past(vec_idx)]);

  // R6
  ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && !cpu_irq && !svc_done) |=> $stable(in_service));

  // R7
  retire_one_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_done && !cpu_ack && in_service != '0) |=>
      ($countones(in_service) == $countones($past(in_service)) - 1));

  // R7
  retire_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(retire_mask));

  // R8
  ack_over_done_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && cpu_irq && svc_done) |=>
      ($countones(in_service) == $countones($past(in_service)) + 1));

  // R5
  grant_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_mask));

endmodule

bind nested_irq_ctrl nested_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_ack     (cpu_ack),
  .svc_done    (svc_done),
  .cpu_irq     (cpu_irq),
  .vec_idx     (vec_idx),
  .in_service  (in_service),
  .grant_mask  (grant_mask),
  .retire_mask (retire_mask)
);

// File: tb/nested_irq_ctrl_test.sv
module nested_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_lines = '0;
  logic       cpu_ack = 1'b0;
  logic       svc_done = 1'b0;
  logic       cpu_irq;
  logic [2:0] vec_idx;
  logic [7:0] in_service;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int exp_q[$];

  nested_irq_ctrl #(.NUM_LINES(8)) uut (
    .clk        (clk),
    .rst        (rst),
    .req_lines  (req_lines),
    .cpu_ack    (cpu_ack),
    .svc_done   (svc_done),
    .cpu_irq    (cpu_irq),
    .vec_idx    (vec_idx),
    .in_service (in_service)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input string tag, input int irq, input int vec, input int isr);
    chk({tag, " irq"}, int'(cpu_irq), irq);
    if (irq != 0) chk({tag, " vec"}, int'(vec_idx), vec);
    chk({tag, " isr"}, int'(in_service), isr);
  endtask

  // driver: expected grant goes to the scoreboard queue
  task automatic grant(input int exp_vec);
    exp_q.push_back(exp_vec);
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
  endtask

  task automatic done_pulse();
    svc_done = 1'b1;
    step();
    svc_done = 1'b0;
  endtask

  // monitor: compares taken acknowledges against the queue
  always begin
    @(negedge clk);
    #3;
    if (!rst && cpu_ack && cpu_irq) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R5 unexpected grant actual=%0d expected=none", vec_idx);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(vec_idx) != e) begin
          failures++;
          $display("FAIL R3 grant vector actual=%0d expected=%0d", vec_idx, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    look("R1 in reset", 0, 0, 0);
    chk("R1 vec", int'(vec_idx), 0);
    rst = 1'b0;
    step();
    look("R1 after reset", 0, 0, 0);

    // R2/R3: single edge, then priority among three
    req_lines[5] = 1'b1; step();
    look("R2 edge", 1, 5, 0);
    req_lines[2] = 1'b1; req_lines[6] = 1'b1; step();
    look("R3 priority", 1, 2, 0);

    // R5/R10/R4: grant 2, lower ones held back
    grant(2);
    look("R5 enter 2", 0, 0, 8'h04);

    // R4 nesting of a higher level
    req_lines[1] = 1'b1; step();
    look("R4 nest visible", 1, 1, 8'h04);
    grant(1);
    look("R10 nested isr", 0, 0, 8'h06);

    // R7 unwind in order
    done_pulse();
    look("R7 retire 1", 0, 0, 8'h04);
    done_pulse();
    look("R7 retire 2", 1, 5, 0);

    // R2 merge: second edge on pending line 5
    req_lines[5] = 1'b0; step();
    req_lines[5] = 1'b1; step();
    look("R2 merge pending", 1, 5, 0);
    grant(5);
    look("R4 lower held", 0, 0, 8'h20);
    done_pulse();
    look("R2 merged once", 1, 6, 0);

    // R2 level held high raises nothing new
    grant(6);
    done_pulse();
    look("R2 level no repeat", 0, 0, 0);

    // R6 ack with nothing eligible, R7 done on empty
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
    look("R6 ack ignored", 0, 0, 0);
    done_pulse();
    look("R7 done on empty", 0, 0, 0);

    // R4 equal priority held back
    req_lines = '0; step();
    req_lines[3] = 1'b1; step();
    grant(3);
    req_lines[3] = 1'b0; step();
    req_lines[3] = 1'b1; step();
    look("R4 equal held", 0, 0, 8'h08);
    done_pulse();
    look("R4 equal released", 1, 3, 0);
    grant(3);
    done_pulse();
    look("R4 cleaned", 0, 0, 0);

    // R8 ack and done together
    req_lines = '0; step();
    req_lines[4] = 1'b1; step();
    grant(4);
    req_lines[0] = 1'b1; step();
    look("R8 setup", 1, 0, 8'h10);
    exp_q.push_back(0);
    cpu_ack = 1'b1; svc_done = 1'b1; step();
    cpu_ack = 1'b0; svc_done = 1'b0;
    look("R8 ack wins", 0, 0, 8'h11);
    done_pulse();
    done_pulse();
    look("R8 unwound", 0, 0, 0);

    // R9 fresh edge during its own ack
    req_lines = '0; step();
    req_lines[7] = 1'b1; step();
    req_lines[7] = 1'b0; step();
    look("R9 pending 7", 1, 7, 0);
    exp_q.push_back(7);
    cpu_ack = 1'b1; req_lines[7] = 1'b1; step();
    cpu_ack = 1'b0;
    look("R9 in service", 0, 0, 8'h80);
    done_pulse();
    look("R9 still pending", 1, 7, 0);

    // R1 reset mid-operation
    req_lines = '0;
    rst = 1'b1; step();
    rst = 1'b0; step();
    look("R1 mid reset", 0, 0, 0);

    chk("R5 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule